// File: doc/BRIEF.md
# Coarse Write-Latency Calibration Sequencer

This block runs on the training side of a DDR memory interface once read eye training has finished. On a fly-by bus, each byte lane can need a different number of whole memory-clock cycles of write latency. The sequencer finds that count for every lane. It takes over the controller's calibration port and writes a known multi-beat pattern. After a fixed gap it reads the pattern back and compares it byte by byte. For each lane that does not match, it pushes that lane's DQ/DQS coarse delay forward by one full clock. The write, read and compare loop repeats until every lane matches.

The per-lane delay counts go straight to the PHY delay lines. Completion is signalled by a sticky ready output. Calibration-select drops one clock after ready rises, and the controller then raises its busy line. If any lane reaches the maximum delay and still fails, the sequencer raises a sticky error instead and releases the port.

Top module: `wrcal_seq`

## Requirements
- R1: The sequencer leaves its start state only when `train_done_i` and `ctl_ready_i` are both high in the same cycle. Until then `cal_sel_o` and `wr_req_o` stay low.
- R2: After starting, `cal_sel_o` rises on the clock edge that follows a cycle in which `ctl_busy_i` is low. It stays low while busy is high.
- R3: Each attempt issues `wr_req_o` as a single-cycle pulse. The pulse occurs only while `cal_sel_o` is high and never in the same cycle as `rd_req_o`.
- R4: The cycle after the controller's k-th `dreq_i` cycle of an attempt, `wdata_o` carries beat k of the pattern and `wmask_o` is all zeros. Beat k counts from 0. In every other cycle `wmask_o` is all ones. The byte of lane l (bits [8l+7:8l]) in beat k equals (0x5A + 37*(k*LANES + l)) mod 256.
- R5: `rd_req_o` rises exactly 19 cycles after the cycle that carries the last write beat, and stays high for one cycle.
- R6: Read bytes are compared only in cycles where `rvalid_i` is high. The j-th such cycle is compared against beat j. `rdata_i` is ignored while `rvalid_i` is low.
- R7: After each attempt, every lane whose bytes mismatched increases its delay field on `lane_dly_o` (bits [DLY_W*l +: DLY_W]) by exactly one. A lane that matched holds its value. Delays never decrease.
- R8: Attempts repeat until all lanes match. With a lane needing delay d, the number of write requests equals the largest d plus one.
- R9: When all lanes match, `ready_o` rises while `cal_sel_o` is still high. `cal_sel_o` falls on the next clock, and `ready_o` then stays high until reset.
- R10: If a lane at delay DLY_MAX still mismatches, `cal_err_o` rises together with the fall of `cal_sel_o` and stays high until reset. `ready_o` never rises, and that lane's delay stays at DLY_MAX.
- R11: During and after reset, all outputs are zero, except `wmask_o`, which is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_done_i | input | 1 | Earlier training stages have finished |
| ctl_ready_i | input | 1 | Controller is ready for calibration |
| ctl_busy_i | input | 1 | Controller owns the calibration port while high |
| cal_sel_o | output | 1 | Sequencer owns the calibration port |
| wr_req_o | output | 1 | Ask the controller to issue a WRITE |
| dreq_i | input | 1 | Controller wants a write beat on the next cycle |
| wdata_o | output | 8*LANES | Write beat |
| wmask_o | output | LANES | Per-lane data mask, 0 means written |
| rd_req_o | output | 1 | Ask the controller to issue a READ |
| rvalid_i | input | 1 | Read beat valid |
| rdata_i | input | 8*LANES | Read beat |
| lane_dly_o | output | DLY_W*LANES | Per-lane coarse delay, in whole clocks |
| ready_o | output | 1 | Calibration finished successfully |
| cal_err_o | output | 1 | A lane ran out of delay range |

## Verification
The bench models a controller and a set of lanes with different hidden latencies. A lane reads back correctly only when its delay equals its target; otherwise it returns the previous beat's byte. That catches a design that shifts delays for lanes that already passed, or stops one attempt early or late. The gap from the last write beat to the read request is counted on every attempt, so an off-by-one gap counter shows up at once. Garbage on the read bus while the valid strobe is low would add extra attempts, and the bench would see wrong final delays. A target beyond the delay range must end in the error flag with the port released; a design that wraps the counter or keeps looping misses that check.

// File: rtl/wrcal_pkg.sv
package wrcal_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_WAITB, ST_WREQ, ST_WDATA, ST_GAP,
      ST_RREQ, ST_RDATA, ST_EVAL, ST_DONE, ST_FIN, ST_ERR
   } wrcal_st_e;

   localparam logic [7:0] PAT_BASE = 8'h5A;
   localparam int         PAT_STEP = 37;

   // odd step keeps all bytes distinct across up to 256 (beat, lane) slots
   function automatic logic [7:0] pat_byte(input int beat, input int lane, input int lanes);
      return PAT_BASE + 8'((beat * lanes + lane) * PAT_STEP);
   endfunction

endpackage

// File: rtl/wrcal_pattern.sv
module wrcal_pattern
   import wrcal_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BEATS  = 4,
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0]   beat_i,
   output logic [8*LANES-1:0]  word_o
);

   localparam int DATA_W = 8 * LANES;

   logic [DATA_W-1:0] tbl [BEATS];

   for (genvar b = 0; b < BEATS; b++) begin : g_beat
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign tbl[b][8*l +: 8] = pat_byte(b, l, LANES);
      end
   end

   if (BEATS == 1) begin : g_single
      assign word_o = tbl[0];
   end else begin : g_multi
      assign word_o = tbl[beat_i];
   end

endmodule

// File: rtl/wrcal_lane.sv
module wrcal_lane #(
   parameter int DLY_W   = 3,
   parameter int DLY_MAX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             chk_i,
   input  logic [7:0]       got_i,
   input  logic [7:0]       exp_i,
   input  logic             eval_i,
   output logic [DLY_W-1:0] dly_o,
   output logic             fail_o,
   output logic             at_max_o
);

   localparam logic [DLY_W-1:0] DLY_TOP = DLY_W'(DLY_MAX);

   logic             fail_q;
   logic [DLY_W-1:0] dly_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fail_q <= 1'b0;
         dly_q  <= '0;
      end else begin
         if (clr_i)
            fail_q <= 1'b0;
         else if (chk_i && (got_i != exp_i))
            fail_q <= 1'b1;
         if (eval_i && fail_q && (dly_q != DLY_TOP))
            dly_q <= dly_q + 1'b1;
      end
   end

   assign dly_o    = dly_q;
   assign fail_o   = fail_q;
   assign at_max_o = (dly_q == DLY_TOP);

endmodule

// File: rtl/wrcal_seq.sv
module wrcal_seq
   import wrcal_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int BEATS   = 4,
   parameter int DLY_W   = 3,
   parameter int DLY_MAX = 5,
   parameter int GAP     = 19
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   train_done_i,
   input  logic                   ctl_ready_i,
   input  logic                   ctl_busy_i,
   output logic                   cal_sel_o,
   output logic                   wr_req_o,
   input  logic                   dreq_i,
   output logic [8*LANES-1:0]     wdata_o,
   output logic [LANES-1:0]       wmask_o,
   output logic                   rd_req_o,
   input  logic                   rvalid_i,
   input  logic [8*LANES-1:0]     rdata_i,
   output logic [DLY_W*LANES-1:0] lane_dly_o,
   output logic                   ready_o,
   output logic                   cal_err_o
);

   localparam int DATA_W = 8 * LANES;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int GAP_W  = $clog2(GAP + 1);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
   localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(GAP - 1);

   if (LANES * BEATS > 256) begin : g_bad_pattern
      $error("pattern cannot keep every byte distinct");
   end
   if (DLY_MAX < 1 || DLY_MAX >= (1 << DLY_W)) begin : g_bad_dly
      $error("DLY_MAX must fit in DLY_W bits and be at least 1");
   end
   if (GAP < 1) begin : g_bad_gap
      $error("GAP must be at least one cycle");
   end

   wrcal_st_e          st_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [GAP_W-1:0]   gap_q;
   logic               sel_q, rdy_q, err_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [LANES-1:0]   wmask_q;
   logic [DATA_W-1:0]  pat_word;
   logic [LANES-1:0]   fail, at_max;
   logic               clr, chk, eval;

   assign clr  = (st_q == ST_WREQ);
   assign chk  = (st_q == ST_RDATA) && rvalid_i;
   assign eval = (st_q == ST_EVAL);

   wrcal_pattern #(
      .LANES  (LANES),
      .BEATS  (BEATS),
      .BEAT_W (BEAT_W)
   ) u_pat (
      .beat_i (beat_q),
      .word_o (pat_word)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wrcal_lane #(
         .DLY_W   (DLY_W),
         .DLY_MAX (DLY_MAX)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (clr),
         .chk_i    (chk),
         .got_i    (rdata_i[8*l +: 8]),
         .exp_i    (pat_word[8*l +: 8]),
         .eval_i   (eval),
         .dly_o    (lane_dly_o[DLY_W*l +: DLY_W]),
         .fail_o   (fail[l]),
         .at_max_o (at_max[l])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         beat_q  <= '0;
         gap_q   <= '0;
         sel_q   <= 1'b0;
         rdy_q   <= 1'b0;
         err_q   <= 1'b0;
         wdata_q <= '0;
         wmask_q <= '1;
      end else begin
         wmask_q <= '1;
         case (st_q)
            ST_IDLE:
               if (train_done_i && ctl_ready_i) st_q <= ST_WAITB;
            ST_WAITB:
               if (!ctl_busy_i) begin
                  sel_q <= 1'b1;
                  st_q  <= ST_WREQ;
               end
            ST_WREQ: begin
               beat_q <= '0;
               st_q   <= ST_WDATA;
            end
            ST_WDATA:
               if (dreq_i) begin
                  wdata_q <= pat_word;
                  wmask_q <= '0;
                  beat_q  <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) begin
                     gap_q <= '0;
                     st_q  <= ST_GAP;
                  end
               end
            ST_GAP: begin
               gap_q <= gap_q + 1'b1;
               if (gap_q == LAST_GAP) st_q <= ST_RREQ;
            end
            ST_RREQ: begin
               beat_q <= '0;
               st_q   <= ST_RDATA;
            end
            ST_RDATA:
               if (rvalid_i) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) st_q <= ST_EVAL;
               end
            ST_EVAL:
               if (|(fail & at_max)) begin
                  err_q <= 1'b1;
                  sel_q <= 1'b0;
                  st_q  <= ST_ERR;
               end else if (fail == '0) begin
                  rdy_q <= 1'b1;
                  st_q  <= ST_DONE;
               end else begin
                  st_q  <= ST_WREQ;
               end
            ST_DONE: begin
               sel_q <= 1'b0;
               st_q  <= ST_FIN;
            end
            default: ;
         endcase
      end
   end

   assign cal_sel_o = sel_q;
   assign wr_req_o  = (st_q == ST_WREQ);
   assign rd_req_o  = (st_q == ST_RREQ);
   assign wdata_o   = wdata_q;
   assign wmask_o   = wmask_q;
   assign ready_o   = rdy_q;
   assign cal_err_o = err_q;

endmodule

// File: rtl/wrcal_seq_chk.sv
module wrcal_seq_chk #(
   parameter int LANES = 4,
   parameter int DLY_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ctl_busy_i,
   input logic                   cal_sel_o,
   input logic                   wr_req_o,
   input logic                   rd_req_o,
   input logic [DLY_W*LANES-1:0] lane_dly_o,
   input logic                   ready_o,
   input logic                   cal_err_o
);

   AST_SEL_AFTER_IDLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_sel_o) |-> $past(!ctl_busy_i)); // R2

   AST_WREQ_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> cal_sel_o); // R3

   AST_WREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |=> !wr_req_o); // R3

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req_o && rd_req_o)); // R3

   AST_RREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o); // R5

   AST_SEL_DROPS_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |=> !cal_sel_o); // R9

   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cal_err_o |=> cal_err_o); // R10

   AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      cal_err_o |-> (!cal_sel_o && !ready_o)); // R10

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      AST_DLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, lane_dly_o[DLY_W*l +: DLY_W]} == {1'b0, $past(lane_dly_o[DLY_W*l +: DLY_W])}) ||
         ({1'b0, lane_dly_o[DLY_W*l +: DLY_W]} == {1'b0, $past(lane_dly_o[DLY_W*l +: DLY_W])} + 1'b1)); // R7
   end

endmodule

bind wrcal_seq wrcal_seq_chk #(
   .LANES (LANES),
   .DLY_W (DLY_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_busy_i (ctl_busy_i),
   .cal_sel_o  (cal_sel_o),
   .wr_req_o   (wr_req_o),
   .rd_req_o   (rd_req_o),
   .lane_dly_o (lane_dly_o),
   .ready_o    (ready_o),
   .cal_err_o  (cal_err_o)
);

// File: tb/wrcal_seq_tb.sv
`timescale 1ns/1ps
module wrcal_seq_tb;

   localparam int LANES   = 4;
   localparam int BEATS   = 4;
   localparam int DLY_W   = 3;
   localparam int DLY_MAX = 5;
   localparam int GAP     = 19;
   localparam int DATA_W  = 8 * LANES;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   train_done_i, ctl_ready_i, ctl_busy_i;
   logic                   cal_sel_o, wr_req_o, rd_req_o;
   logic                   dreq_i, rvalid_i;
   logic [DATA_W-1:0]      wdata_o, rdata_i;
   logic [LANES-1:0]       wmask_o;
   logic [DLY_W*LANES-1:0] lane_dly_o;
   logic                   ready_o, cal_err_o;

   int n_chk  = 0;
   int n_fail = 0;
   int tgt [LANES];
   logic [7:0] wbuf [BEATS][LANES];
   logic [DATA_W-1:0] exp_q [$];

   always #2.5 clk = ~clk;

   wrcal_seq #(
      .LANES(LANES), .BEATS(BEATS), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX), .GAP(GAP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .train_done_i(train_done_i), .ctl_ready_i(ctl_ready_i),
      .ctl_busy_i(ctl_busy_i), .cal_sel_o(cal_sel_o), .wr_req_o(wr_req_o), .dreq_i(dreq_i),
      .wdata_o(wdata_o), .wmask_o(wmask_o), .rd_req_o(rd_req_o), .rvalid_i(rvalid_i),
      .rdata_i(rdata_i), .lane_dly_o(lane_dly_o), .ready_o(ready_o), .cal_err_o(cal_err_o)
   );

   function automatic logic [7:0] exp_byte(input int k, input int l);
      return 8'(32'h5A + 37 * (k * LANES + l));
   endfunction

   function automatic logic [DATA_W-1:0] exp_word(input int k);
      logic [DATA_W-1:0] w;
      for (int l = 0; l < LANES; l++) w[8*l +: 8] = exp_byte(k, l);
      return w;
   endfunction

   function automatic int dly_of(input int l);
      return int'(lane_dly_o[DLY_W*l +: DLY_W]);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic do_reset;
      rst_n = 1'b0; train_done_i = 1'b0; ctl_ready_i = 1'b0; ctl_busy_i = 1'b1;
      dreq_i = 1'b0; rvalid_i = 1'b0; rdata_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // monitor: pops expected write beats as the design presents them
   initial begin
      logic pend;
      forever begin
         @(posedge clk);
         pend = dreq_i;
         @(negedge clk);
         if (pend) begin
            if (exp_q.size() == 0) chk("R4 unexpected beat", 64'(wdata_o), 64'hx);
            else begin
               chk("R4 write data", 64'(wdata_o), 64'(exp_q.pop_front()));
               chk("R4 mask on beat", 64'(wmask_o), 64'(0));
            end
         end else if (rst_n) begin
            chk("R4 mask idle", 64'(wmask_o), 64'({LANES{1'b1}}));
         end
      end
   end

   // controller and DRAM model; driver pushes expected beats per attempt
   task automatic run_cal(output int attempts);
      attempts = 0;
      forever begin
         while (!wr_req_o && !ready_o && !cal_err_o) @(negedge clk);
         if (!wr_req_o) break;
         attempts++;
         for (int k = 0; k < BEATS; k++) exp_q.push_back(exp_word(k));
         @(negedge clk);
         for (int k = 0; k < BEATS; k++) begin
            dreq_i = 1'b1;
            @(negedge clk);
            dreq_i = 1'b0;
            for (int l = 0; l < LANES; l++) wbuf[k][l] = wdata_o[8*l +: 8];
            if (k < BEATS - 1) @(negedge clk);
         end
         begin
            int gap = 0;
            do begin
               @(negedge clk);
               gap++;
            end while (!rd_req_o && gap < 60);
            chk("R5 write-to-read gap", 64'(gap), 64'(GAP));
         end
         repeat (2) @(negedge clk);
         for (int k = 0; k < BEATS; k++) begin
            rvalid_i = 1'b1;
            for (int l = 0; l < LANES; l++)
               rdata_i[8*l +: 8] = (dly_of(l) == tgt[l]) ? wbuf[k][l] :
                                   (k > 0) ? wbuf[k-1][l] : 8'h00;
            @(negedge clk);
            rvalid_i = 1'b0;
            rdata_i  = '1;   // R6: junk while strobe is low
            if (k < BEATS - 1) @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int att;
      do_reset();
      // R11 reset state
      chk("R11 cal_sel", 64'(cal_sel_o), 0);
      chk("R11 wr_req", 64'(wr_req_o), 0);
      chk("R11 rd_req", 64'(rd_req_o), 0);
      chk("R11 ready", 64'(ready_o), 0);
      chk("R11 error", 64'(cal_err_o), 0);
      chk("R11 delays", 64'(lane_dly_o), 0);
      chk("R11 mask", 64'(wmask_o), 64'({LANES{1'b1}}));

      // R1 start gating
      ctl_busy_i = 1'b0; ctl_ready_i = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 no start without train_done", 64'({cal_sel_o, wr_req_o}), 0);
      ctl_ready_i = 1'b0; train_done_i = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 no start without ctl_ready", 64'({cal_sel_o, wr_req_o}), 0);

      // R2 busy holds off select
      ctl_busy_i = 1'b1; ctl_ready_i = 1'b1;
      repeat (20) @(negedge clk);
      chk("R2 select held off by busy", 64'(cal_sel_o), 0);
      ctl_busy_i = 1'b0;
      @(negedge clk);
      chk("R2 select after busy drop", 64'(cal_sel_o), 1);

      // test 1: mixed lane latencies
      tgt = '{0, 2, 1, 4};
      run_cal(att);
      chk("R8 attempts mixed", 64'(att), 5);
      for (int l = 0; l < LANES; l++) chk("R7 final delay mixed", 64'(dly_of(l)), 64'(tgt[l]));
      chk("R9 ready with select high", 64'({ready_o, cal_sel_o, cal_err_o}), 64'(3'b110));
      @(negedge clk);
      chk("R9 select drops next clock", 64'({ready_o, cal_sel_o}), 64'(2'b10));
      ctl_busy_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R9 ready sticky", 64'(ready_o), 1);
      chk("R4 all beats seen", 64'(exp_q.size()), 0);

      // test 2: all lanes aligned
      do_reset();
      tgt = '{0, 0, 0, 0};
      train_done_i = 1'b1; ctl_ready_i = 1'b1; ctl_busy_i = 1'b0;
      run_cal(att);
      chk("R8 attempts aligned", 64'(att), 1);
      chk("R7 delays hold at zero", 64'(lane_dly_o), 0);
      chk("R9 ready aligned", 64'(ready_o), 1);

      // test 3: one lane out of range
      do_reset();
      tgt = '{1, 0, 3, 7};
      train_done_i = 1'b1; ctl_ready_i = 1'b1; ctl_busy_i = 1'b0;
      run_cal(att);
      chk("R10 error flag", 64'({cal_err_o, ready_o, cal_sel_o}), 64'(3'b100));
      chk("R10 attempts to limit", 64'(att), 64'(DLY_MAX + 1));
      chk("R10 lane at max", 64'(dly_of(3)), 64'(DLY_MAX));
      chk("R7 lane0 held", 64'(dly_of(0)), 1);
      chk("R7 lane2 held", 64'(dly_of(2)), 3);
      repeat (5) @(negedge clk);
      chk("R10 error sticky", 64'({cal_err_o, ready_o}), 64'(2'b10));

      summary();
      $finish;
   end

endmodule